// File: doc/BRIEF.md
# Command-Decoded Single-Port Byte Memory

This block is a byte-wide single-port memory that is reached through a stream of 10-bit command words rather than through separate address and data buses. The two upper bits of each word are an opcode. The lower eight bits hold the payload. An upstream serial front end delivers each assembled word together with a valid strobe, and the memory acts on that word at the next rising clock edge.

Two address pointers are kept apart: one for writes and one for reads. A host first loads a pointer, then sends data or a read trigger, and each data or trigger word uses the pointer most recently loaded. A read produces the stored byte on a registered output along with a one-cycle valid pulse, ready for the front end to shift back out.

Top module: `cmd_byte_ram`

## Requirements
- R1: While `cmd_vld` is low, no pointer, memory word or output changes, and `rd_vld` stays low.
- R2: A valid word with opcode `cmd_word[9:8]=2'b00` loads `cmd_word[7:0]` (its low ADDR_W bits) into the write pointer.
- R3: A valid word with opcode `2'b01` stores `cmd_word[7:0]` at the location held in the write pointer. The write pointer itself is left unchanged, so repeated data words overwrite the same location.
- R4: A valid word with opcode `2'b10` loads `cmd_word[7:0]` into the read pointer, independently of the write pointer.
- R5: A valid word with opcode `2'b11` places the byte at the read-pointer location on `rd_data` one clock later and raises `rd_vld` in that same cycle. The low eight bits of the trigger word are ignored.
- R6: `rd_vld` is high for exactly one cycle for each accepted read trigger and low in every other cycle. `rd_data` holds its value between reads.
- R7: A synchronous active-low reset clears both pointers, `rd_data` and `rd_vld`, and leaves the memory contents as they were.
- R8: Depth and address width are parameters. The elaboration checks that DEPTH is at most 2**ADDR_W and that the payload field is at least ADDR_W bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_vld | input | 1 | Qualifies cmd_word for this cycle |
| cmd_word | input | 10 | Opcode in [9:8], payload in [7:0] |
| rd_data | output | 8 | Registered byte from the latest read |
| rd_vld | output | 1 | One-cycle pulse marking fresh rd_data |

## Verification
The case hardest to reach from the ports is showing that the memory survives a reset. The stimulus writes known bytes, pulses reset in the middle of the run, and then has to reload the read pointer, because reset has set it back to zero, before reading the bytes back. A second difficult case is telling the two pointers apart. For this the bench loads them with different values in between writes and checks that each read returns the byte stored at the read pointer and not at the write pointer. Back-to-back read triggers, writes to the same location, and trigger payloads that hold nonzero garbage are also driven to cover R3, R5 and R6.

// File: rtl/cmd_byte_ram_pkg.sv
package cmd_byte_ram_pkg;
   typedef enum logic [1:0] {
      OP_SET_WADDR = 2'b00,
      OP_WRITE     = 2'b01,
      OP_SET_RADDR = 2'b10,
      OP_READ      = 2'b11
   } op_e;
endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
   import cmd_byte_ram_pkg::*;
#(
   parameter int WORD_W = 10
) (
   input  logic              vld,
   input  logic [WORD_W-1:0] word,
   output logic              set_w,
   output logic              wr,
   output logic              set_r,
   output logic              rd
);
   op_e op;
   assign op = op_e'(word[WORD_W-1 -: 2]);
   always_comb begin
      set_w = 1'b0; wr = 1'b0; set_r = 1'b0; rd = 1'b0;
      if (vld) begin
         unique case (op)
            OP_SET_WADDR: set_w = 1'b1;
            OP_WRITE:     wr    = 1'b1;
            OP_SET_RADDR: set_r = 1'b1;
            OP_READ:      rd    = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cbr_ptr.sv
module cbr_ptr #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] val,
   output logic [ADDR_W-1:0] ptr
);
   always_ff @(posedge clk) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= val;
   end

   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(ptr));
endmodule

// File: rtl/cbr_array.sv
module cbr_array #(
   parameter int DEPTH  = 256,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   output logic              rvld
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
         rvld  <= 1'b0;
      end else begin
         rvld <= re;
         if (re) rdata <= mem[raddr];
      end
   end

   p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> !rvld);
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(rdata));
   p_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      re |=> rvld);
endmodule

// File: rtl/cmd_byte_ram.sv
module cmd_byte_ram #(
   parameter int DEPTH  = 256,
   parameter int ADDR_W = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_vld,
   input  logic [9:0] cmd_word,
   output logic [7:0] rd_data,
   output logic       rd_vld
);
   localparam int WORD_W = 10;
   localparam int PAY_W  = WORD_W - 2;

   if (DEPTH > (1 << ADDR_W)) begin : g_bad_depth
      $error("DEPTH exceeds address space (R8)");
   end
   if (ADDR_W > PAY_W || ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must fit the payload field (R8)");
   end

   logic set_w, wr, set_r, rd;
   logic [ADDR_W-1:0] wptr, rptr;

   cbr_decode #(.WORD_W(WORD_W)) u_dec (
      .vld(cmd_vld), .word(cmd_word),
      .set_w(set_w), .wr(wr), .set_r(set_r), .rd(rd));

   cbr_ptr #(.ADDR_W(ADDR_W)) u_wptr (
      .clk(clk), .rst_n(rst_n), .load(set_w),
      .val(cmd_word[ADDR_W-1:0]), .ptr(wptr));

   cbr_ptr #(.ADDR_W(ADDR_W)) u_rptr (
      .clk(clk), .rst_n(rst_n), .load(set_r),
      .val(cmd_word[ADDR_W-1:0]), .ptr(rptr));

   cbr_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(PAY_W)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .we(wr), .waddr(wptr), .wdata(cmd_word[PAY_W-1:0]),
      .re(rd), .raddr(rptr), .rdata(rd_data), .rvld(rd_vld));

   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({set_w, wr, set_r, rd}));
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_vld |=> !rd_vld);
   p_rst_r7: assert property (@(posedge clk)
      !rst_n |=> (!rd_vld && rd_data == '0));
endmodule

// File: tb/tb_cmd_byte_ram.sv
module tb_cmd_byte_ram;
   logic clk = 0, rst_n = 0, cmd_vld = 0;
   logic [9:0] cmd_word = '0;
   logic [7:0] rd_data;
   logic rd_vld;
   int checks = 0, fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   cmd_byte_ram dut (.clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld),
      .cmd_word(cmd_word), .rd_data(rd_data), .rd_vld(rd_vld));

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] op, input logic [7:0] pay);
      @(negedge clk);
      cmd_vld = 1; cmd_word = {op, pay};
      @(negedge clk);
      cmd_vld = 0; cmd_word = '0;
   endtask

   // read: trigger, then sample at the next negedge (one clock after acceptance)
   task automatic rd_at(input string req, input logic [7:0] a, input logic [7:0] exp);
      send(2'b10, a);
      @(negedge clk);
      cmd_vld = 1; cmd_word = {2'b11, 8'h5A};
      @(negedge clk);
      cmd_vld = 0;
      chk(req, {rd_vld, rd_data}, {1'b1, exp});
      @(negedge clk);
      chk({req, "_pulse R6"}, {rd_vld, rd_data}, {1'b0, exp});
   endtask

   task automatic t_reset;
      chk("R7 reset", {rd_vld, rd_data}, 9'h0);
   endtask

   task automatic t_basic;
      send(2'b00, 8'h10); send(2'b01, 8'hA5);
      send(2'b00, 8'hFF); send(2'b01, 8'h3C);
      send(2'b00, 8'h00); send(2'b01, 8'h77);
      rd_at("R2/R3/R5 a10", 8'h10, 8'hA5);
      rd_at("R2/R3/R5 aFF", 8'hFF, 8'h3C);
      rd_at("R2/R5 a00", 8'h00, 8'h77);
   endtask

   task automatic t_overwrite;
      send(2'b00, 8'h20); send(2'b01, 8'h11); send(2'b01, 8'h22);
      rd_at("R3 overwrite", 8'h20, 8'h22);
   endtask

   task automatic t_ptr_indep;
      send(2'b10, 8'h10);
      send(2'b00, 8'h30); send(2'b01, 8'h99);
      @(negedge clk); cmd_vld = 1; cmd_word = {2'b11, 8'hFF};
      @(negedge clk); cmd_vld = 0;
      chk("R4 independent ptr", {rd_vld, rd_data}, {1'b1, 8'hA5});
   endtask

   task automatic t_b2b;
      send(2'b10, 8'hFF);
      @(negedge clk); cmd_vld = 1; cmd_word = {2'b11, 8'h00};
      @(negedge clk);
      chk("R6 b2b first", {rd_vld, rd_data}, {1'b1, 8'h3C});
      @(negedge clk); cmd_vld = 0;
      chk("R6 b2b second", {rd_vld, rd_data}, {1'b1, 8'h3C});
      @(negedge clk);
      chk("R6 b2b end", rd_vld, 1'b0);
   endtask

   task automatic t_ignore;
      // R1: valid low with write/read opcodes on the bus
      @(negedge clk); cmd_vld = 0; cmd_word = {2'b01, 8'hEE};
      @(negedge clk); cmd_word = {2'b11, 8'h00};
      @(negedge clk);
      chk("R1 no pulse", rd_vld, 1'b0);
      cmd_word = {2'b00, 8'h10};
      @(negedge clk); cmd_word = '0;
      rd_at("R1 no write", 8'h30, 8'h99);
   endtask

   task automatic t_mem_survives;
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      chk("R7 reset outputs", {rd_vld, rd_data}, 9'h0);
      // read pointer reset to 0 -> location 0 holds 77
      @(negedge clk); cmd_vld = 1; cmd_word = {2'b11, 8'h00};
      @(negedge clk); cmd_vld = 0;
      chk("R7 rptr cleared", {rd_vld, rd_data}, {1'b1, 8'h77});
      rd_at("R7 mem kept", 8'h10, 8'hA5);
      // write pointer reset to 0
      send(2'b01, 8'h42);
      rd_at("R7 wptr cleared", 8'h00, 8'h42);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      t_basic();
      t_overwrite();
      t_ptr_indep();
      t_b2b();
      t_ignore();
      t_mem_survives();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule